// File: doc/BRIEF.md
# Sleep-Entry Main Clock Switcher

This block decides which oscillator drives the main clock while the system goes into and comes out of a low-power wait state. It runs on the always-available internal RC clock. When a sleep request arrives, it records the main source that is selected at that moment and moves the glitch-free mux to the RC clock. It holds the mux there for a fixed settle time and then switches off every oscillator except the RC one. When a wake event arrives, it turns the recorded oscillator back on and waits for that oscillator's ready flag, which it first passes through a synchronizer. It then switches the mux back to the recorded source and waits out a second settle time.

Software can skip the RC detour for oscillators that start quickly. It does this by setting that source's bit in a per-source fast-sleep mask. With the bit set, the recorded oscillator stays on and stays on the mux for the whole sleep. A mask that has bits set, but not the bit of the current source, is a configuration error. When that happens the block raises a flag and falls back to the safe detour instead of risking a hang on wake-up.

Top module: `mcs_clk_switcher`

## Requirements
- R1: While reset is held and after it is released, busy and cfg_err are 0, mux_sel equals src_sel, and osc_en has exactly two bits set: bit 0 (the RC source) and bit src_sel.
- R2: A sleep request taken while idle, with fast_mask[src_sel] clear, moves mux_sel to 0 (the RC source) on the next clock edge. The recorded oscillator's osc_en bit stays set for exactly 3 cycles. After that, osc_en is 0001.
- R3: After a detoured entry, and until a wake event is seen, osc_en stays 0001, mux_sel stays 0 and busy stays 1.
- R4: On a wake event during detoured sleep, the recorded oscillator's osc_en bit returns on the next edge and mux_sel stays 0 until its osc_rdy bit has been high through two synchronizer flops. mux_sel moves to the recorded source on the third edge after osc_rdy rises. busy then stays 1 for 3 cycles and falls on the fourth edge.
- R5: The source recorded at sleep acceptance is not affected by src_sel changes while busy. mux_sel and osc_en follow the recorded source until busy falls, and follow src_sel again once busy falls.
- R6: With fast_mask[src_sel] set, a sleep request makes busy 1 on the next edge. mux_sel and osc_en stay unchanged during the sleep. A wake event returns busy to 0 on the next edge.
- R7: A sleep request accepted with fast_mask non-zero but fast_mask[src_sel] clear sets cfg_err and takes the detoured path. cfg_err keeps its value until the next accepted request and is cleared by an accepted request without the mismatch.
- R8: A wake event seen during the 3-cycle switch to RC, or during the single cycle with oscillators off, is remembered. Entry completes with osc_en at 0001 for one cycle, then the wake sequence starts with no further wake event.
- R9: A sleep request is ignored while busy, and a wake event is ignored while idle.
- R10: The osc_en bit of the RC source (bit 0) is never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on RC clock that runs the block |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter the wait state, sampled while idle |
| wake_evt | input | 1 | Wake event |
| src_sel | input | SELW | Main clock source chosen by software |
| fast_mask | input | NUM_SRC | Per-source bits that skip the RC detour |
| osc_rdy | input | NUM_SRC | Asynchronous oscillator ready flags |
| osc_en | output | NUM_SRC | Oscillator enables |
| mux_sel | output | SELW | Select for the glitch-free main clock mux |
| busy | output | 1 | High whenever the sequencer is not idle |
| cfg_err | output | 1 | Fast-sleep mask does not match the recorded source |

## Verification
A wake event can arrive in the same cycle as the entry switch is still settling, either during the three-cycle switch to RC or in the cycle when the oscillators are turned off. The bench provokes this by pulsing wake_evt at each of those two moments, for several sources. It then judges two things: that osc_en still drops to the RC source alone for one cycle, and that the restart follows without a second wake event. A change of src_sel while the sequencer is busy is also made to collide with the return switch. This shows that the mux comes back to the recorded source and not the new one.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_TO_RC     = 3'd1,
        ST_OSC_OFF   = 3'd2,
        ST_SLEEP     = 3'd3,
        ST_OSC_START = 3'd4,
        ST_BACK      = 3'd5
    } mcs_state_e;
endpackage

// File: rtl/mcs_rdy_sync.sv
module mcs_rdy_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/mcs_dwell_cnt.sv
module mcs_dwell_cnt #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)             cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == LAST);

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/mcs_src_decode.sv
module mcs_src_decode
    import mcs_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int RC_SRC  = 0,
    parameter int SELW    = 2
) (
    input  mcs_state_e        state,
    input  logic              fast,
    input  logic [SELW-1:0]   live_sel,
    input  logic [SELW-1:0]   saved_sel,
    output logic [SELW-1:0]   mux_sel,
    output logic [NUM_SRC-1:0] osc_en
);
    logic [SELW-1:0] tgt_sel;
    logic            tgt_on;

    always_comb begin
        tgt_sel = (state == ST_RUN) ? live_sel : saved_sel;
        unique case (state)
            ST_RUN, ST_TO_RC, ST_OSC_START, ST_BACK: tgt_on = 1'b1;
            ST_SLEEP:                                tgt_on = fast;
            default:                                 tgt_on = 1'b0;
        endcase
        unique case (state)
            ST_RUN:   mux_sel = live_sel;
            ST_BACK:  mux_sel = saved_sel;
            ST_SLEEP: mux_sel = fast ? saved_sel : SELW'(RC_SRC);
            default:  mux_sel = SELW'(RC_SRC);
        endcase
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_en
        if (i == RC_SRC) begin : g_rc
            assign osc_en[i] = 1'b1;
        end else begin : g_osc
            assign osc_en[i] = tgt_on && (tgt_sel == SELW'(i));
        end
    end
endmodule

// File: rtl/mcs_clk_switcher.sv
module mcs_clk_switcher
    import mcs_pkg::*;
#(
    parameter int NUM_SRC       = 4,
    parameter int RC_SRC        = 0,
    parameter int SWITCH_CYCLES = 3,
    parameter int SYNC_STAGES   = 2,
    localparam int SELW         = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               wake_evt,
    input  logic [SELW-1:0]    src_sel,
    input  logic [NUM_SRC-1:0] fast_mask,
    input  logic [NUM_SRC-1:0] osc_rdy,
    output logic [NUM_SRC-1:0] osc_en,
    output logic [SELW-1:0]    mux_sel,
    output logic               busy,
    output logic               cfg_err
);
    typedef struct packed {
        mcs_state_e      state;
        logic [SELW-1:0] saved;
        logic            fast;
        logic            wake_pend;
        logic            cfg_err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [NUM_SRC-1:0] rdy_s;
    logic               dwell_run;
    logic               dwell_done;

    mcs_rdy_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (osc_rdy),
        .sync_out (rdy_s)
    );

    assign dwell_run = (ctl_q.state == ST_TO_RC) || (ctl_q.state == ST_BACK);

    mcs_dwell_cnt #(.CYCLES(SWITCH_CYCLES)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (dwell_run),
        .done  (dwell_done)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (sleep_req) begin
                    ctl_d.saved     = src_sel;
                    ctl_d.wake_pend = 1'b0;
                    ctl_d.cfg_err   = (fast_mask != '0) && !fast_mask[src_sel];
                    ctl_d.fast      = fast_mask[src_sel];
                    ctl_d.state     = fast_mask[src_sel] ? ST_SLEEP : ST_TO_RC;
                end
            end
            ST_TO_RC: begin
                if (wake_evt)   ctl_d.wake_pend = 1'b1;
                if (dwell_done) ctl_d.state     = ST_OSC_OFF;
            end
            ST_OSC_OFF: begin
                ctl_d.wake_pend = 1'b0;
                ctl_d.state = (ctl_q.wake_pend || wake_evt) ? ST_OSC_START : ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_evt) ctl_d.state = ctl_q.fast ? ST_RUN : ST_OSC_START;
            end
            ST_OSC_START: begin
                if (rdy_s[ctl_q.saved]) ctl_d.state = ST_BACK;
            end
            ST_BACK: begin
                if (dwell_done) ctl_d.state = ST_RUN;
            end
            default: ctl_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_RUN, saved: '0, fast: 1'b0,
                       wake_pend: 1'b0, cfg_err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    mcs_src_decode #(.NUM_SRC(NUM_SRC), .RC_SRC(RC_SRC), .SELW(SELW)) u_dec (
        .state     (ctl_q.state),
        .fast      (ctl_q.fast),
        .live_sel  (src_sel),
        .saved_sel (ctl_q.saved),
        .mux_sel   (mux_sel),
        .osc_en    (osc_en)
    );

    assign busy    = (ctl_q.state != ST_RUN);
    assign cfg_err = ctl_q.cfg_err;

    // R10
    rc_always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en[RC_SRC]);

    // R5
    saved_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctl_q.saved));

    // R4
    back_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_BACK && $past(ctl_q.state) == ST_OSC_START)
        |-> $past(rdy_s[ctl_q.saved]));

    // R2
    off_after_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_OSC_OFF) |-> ($past(ctl_q.state) == ST_TO_RC && $past(dwell_done)));

    // R3
    detour_on_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_SLEEP && !ctl_q.fast) |-> (mux_sel == SELW'(RC_SRC)));

    // R1
    idle_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mux_sel == src_sel));
endmodule

// File: tb/tb_mcs_clk_switcher.sv
`timescale 1ns/1ps
module tb_mcs_clk_switcher;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic [1:0] src_sel = 2'd2;
    logic [3:0] fast_mask = 4'b0000;
    logic [3:0] osc_rdy = 4'b0001;
    logic [3:0] osc_en;
    logic [1:0] mux_sel;
    logic       busy;
    logic       cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mcs_clk_switcher dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
        .src_sel(src_sel), .fast_mask(fast_mask), .osc_rdy(osc_rdy),
        .osc_en(osc_en), .mux_sel(mux_sel), .busy(busy), .cfg_err(cfg_err)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int en_of(int s);
        return (1 << s) | 1;
    endfunction

    // wmode 0: wake in sleep, 1: wake during switch to RC, 2: wake in osc-off cycle
    task automatic detour(int s, logic [3:0] mask, int exp_err, int wmode);
        int alt;
        int wait_n;
        alt = (s == 3) ? 1 : s + 1;
        src_sel = 2'(s);
        fast_mask = mask;
        osc_rdy = 4'b0001;
        repeat (4) @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R2", "mux to rc", int'(mux_sel), 0);
        chk("R2", "osc held", int'(osc_en), en_of(s));
        chk("R7", "cfg_err", int'(cfg_err), exp_err);
        if (wmode == 1) wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        chk("R2", "osc held c2", int'(osc_en), en_of(s));
        @(negedge clk);
        chk("R2", "osc held c3", int'(osc_en), en_of(s));
        @(negedge clk);
        chk("R2", "osc off", int'(osc_en), 1);
        chk("R8", "off cycle mux", int'(mux_sel), 0);
        if (wmode == 2) wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        if (wmode == 0) begin
            for (int k = 0; k < 3; k++) begin
                chk("R3", "sleep osc", int'(osc_en), 1);
                chk("R3", "sleep busy", int'(busy), 1);
                @(negedge clk);
            end
            src_sel = 2'(alt);
            sleep_req = 1'b1;
            @(negedge clk);
            sleep_req = 1'b0;
            chk("R9", "req ignored in sleep", int'(osc_en), 1);
            chk("R3", "sleep mux", int'(mux_sel), 0);
            wake_evt = 1'b1;
            @(negedge clk);
            wake_evt = 1'b0;
        end
        chk((wmode == 0) ? "R4" : "R8", "restart osc", int'(osc_en), en_of(s));
        chk("R4", "mux rc in start", int'(mux_sel), 0);
        wait_n = s + 1;
        repeat (wait_n) begin
            @(negedge clk);
            chk("R4", "waits ready", int'(mux_sel), 0);
        end
        osc_rdy[s] = 1'b1;
        @(negedge clk);
        chk("R4", "sync 1", int'(mux_sel), 0);
        @(negedge clk);
        chk("R4", "sync 2", int'(mux_sel), 0);
        @(negedge clk);
        chk("R5", "back to saved", int'(mux_sel), s);
        chk("R5", "saved osc", int'(osc_en), en_of(s));
        chk("R4", "busy back 1", int'(busy), 1);
        @(negedge clk);
        chk("R4", "busy back 2", int'(busy), 1);
        @(negedge clk);
        chk("R4", "busy back 3", int'(busy), 1);
        @(negedge clk);
        chk("R4", "idle", int'(busy), 0);
        chk("R5", "follows live", int'(mux_sel), int'(src_sel));
        osc_rdy = 4'b0001;
        src_sel = 2'(s);
    endtask

    task automatic fastpath(int s);
        src_sel = 2'(s);
        fast_mask = 4'(1 << s);
        repeat (2) @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R6", "fast busy", int'(busy), 1);
            chk("R6", "fast mux", int'(mux_sel), s);
            chk("R6", "fast osc", int'(osc_en), en_of(s));
            chk("R7", "fast no err", int'(cfg_err), 0);
            @(negedge clk);
        end
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        chk("R6", "fast wake idle", int'(busy), 0);
        chk("R6", "fast wake mux", int'(mux_sel), s);
    endtask

    initial begin
        #1;
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "mux in reset", int'(mux_sel), 2);
        chk("R1", "osc in reset", int'(osc_en), en_of(2));
        chk("R1", "err in reset", int'(cfg_err), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after", int'(busy), 0);
        chk("R1", "osc after", int'(osc_en), en_of(2));
        wake_evt = 1'b1;
        @(negedge clk);
        wake_evt = 1'b0;
        @(negedge clk);
        chk("R9", "wake ignored idle", int'(busy), 0);
        chk("R9", "wake ignored osc", int'(osc_en), en_of(2));
        for (int s = 1; s < 4; s++) begin
            detour(s, 4'(1 << ((s % 3) + 1)), 1, 0);
        end
        for (int s = 1; s < 4; s++) begin
            for (int w = 0; w < 3; w++) begin
                detour(s, 4'b0000, 0, w);
            end
        end
        for (int s = 0; s < 4; s++) begin
            fastpath(s);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule